// File: doc/BRIEF.md
# ATM Cell Delineation Tracker

This block decides where ATM cell boundaries lie in a received stream from the outcome of the header error check on each cell. It keeps a three-state machine: searching, tentatively locked and locked. The search for a boundary, whether bit by bit or byte by byte, happens upstream. Upstream raises a strobe when it finds a candidate boundary whose header check passes. Once the machine has left the search state, each header verdict arrives as a valid pulse that carries a pass/fail bit. The machine counts runs of passes and failures to decide when to lock and when to give up.

Around the state machine sit two millisecond timers driven by a one-cycle tick. One measures how long delineation has been out of lock. The other measures how long it has stayed locked. Together they raise and later clear a loss-of-delineation alarm against a programmable limit. The block also gives a per-cell accept decision for the tentative state. A configuration input lets cells with a good header through while the lock is not yet confirmed.

Top module: `cell_sync_tracker`

## Requirements
- R1: After reset the state output is searching (code 0), the out-of-delineation flag is 1, the loss flag is 0 and accept is 0.
- R2: In searching (code 0), a cycle with the candidate strobe high moves the state to tentative (code 1) at the next edge. Header verdicts have no effect in this state, and the candidate strobe has no effect in any other state.
- R3: In tentative (code 1), a valid cell with a failed header check returns the state to searching at the next edge.
- R4: In tentative, DELTA (default 6) consecutive valid cells with a passing header check move the state to locked (code 2). The count restarts from zero on every entry to tentative.
- R5: In locked, ALPHA (default 7) consecutive valid cells with a failed header check return the state to searching. Any passing cell restarts that run.
- R6: The out-of-delineation output is 1 exactly when the state is not locked.
- R7: Accept is high in the same cycle as a valid cell only when the state is tentative, the header check passes and the pass-through configuration bit is 1. Otherwise it is 0.
- R8: The loss flag rises at the edge of the tick that makes the out-of-delineation time reach the limit M (M ticks counted while not locked). M is at least 1.
- R9: The loss flag falls at the edge of the tick that makes the time spent in locked exceed M, that is on the (M+1)th tick. Leaving locked restarts this count.
- R10: The out-of-delineation timer restarts from zero whenever the state is locked, so a later loss of lock counts a fresh M ticks. A tick in the cycle of a state change counts toward the state held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_found | input | 1 | Upstream found a boundary with a good header (used in searching) |
| cell_vld | input | 1 | Header verdict for one cell is present |
| hec_ok | input | 1 | Verdict: 1 = header check passed |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| m_limit | input | MW (8) | Persistence limit M in ticks |
| pass_presync | input | 1 | Accept good cells while tentative |
| state | output | 2 | 0 searching, 1 tentative, 2 locked |
| ocd | output | 1 | Out of cell delineation |
| lcd | output | 1 | Loss of cell delineation |
| accept | output | 1 | Write the current cell onward |

## Verification
The assertions assume that m_limit is at least 1 and stays steady while a timer is running, and that ms_tick and cell_vld are single-cycle pulses sampled at each edge. The bench only changes m_limit and pass_presync during reset. It holds M between 1 and 5, and it spaces ticks a few cycles apart so that both thresholds are crossed many times. The verdict stream switches between mostly-good, mostly-bad and mixed patterns, so that every transition path and counter restart occurs.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [1:0] {
    CDL_HUNT    = 2'd0,
    CDL_PRESYNC = 2'd1,
    CDL_SYNC    = 2'd2
  } cdl_state_e;
endpackage

// File: rtl/cdl_state_fsm.sv
module cdl_state_fsm
  import cdl_pkg::*;
#(
  parameter int ALPHA = 7,
  parameter int DELTA = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cand_found,
  input  logic       cell_vld,
  input  logic       hec_ok,
  output cdl_state_e st_q
);
  localparam int RMAX = (ALPHA > DELTA) ? ALPHA : DELTA;
  localparam int RW   = $clog2(RMAX + 1);

  cdl_state_e    st_d;
  logic [RW-1:0] run_q, run_d;
  logic          upd_en;

  assign upd_en = cand_found | cell_vld;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    unique case (st_q)
      CDL_HUNT: begin
        if (cand_found) begin
          st_d  = CDL_PRESYNC;
          run_d = '0;
        end
      end
      CDL_PRESYNC: begin
        if (cell_vld) begin
          if (!hec_ok) begin
            st_d  = CDL_HUNT;
            run_d = '0;
          end else if (run_q == RW'(DELTA - 1)) begin
            st_d  = CDL_SYNC;
            run_d = '0;
          end else begin
            run_d = run_q + RW'(1);
          end
        end
      end
      CDL_SYNC: begin
        if (cell_vld) begin
          if (hec_ok) begin
            run_d = '0;
          end else if (run_q == RW'(ALPHA - 1)) begin
            st_d  = CDL_HUNT;
            run_d = '0;
          end else begin
            run_d = run_q + RW'(1);
          end
        end
      end
      default: begin
        st_d  = CDL_HUNT;
        run_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CDL_HUNT;
      run_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  // R2: searching holds without a candidate
  a_r2_hunt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CDL_HUNT && !cand_found) |=> st_q == CDL_HUNT);
  // R2: lock is never reached straight from searching
  a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CDL_HUNT) |=> st_q != CDL_SYNC);
  // R3: a bad header while tentative drops back
  a_r3_presync_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CDL_PRESYNC && cell_vld && !hec_ok) |=> st_q == CDL_HUNT);
  // R5: a good header in lock keeps lock
  a_r5_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CDL_SYNC && (!cell_vld || hec_ok)) |=> st_q == CDL_SYNC);
  // R1: only legal codes appear
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'd3);
endmodule

// File: rtl/cdl_ms_timer.sv
module cdl_ms_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | tick;

  always_comb begin
    if (clr)                         cnt_d = '0;
    else if (tick && cnt_q != '1)    cnt_d = cnt_q + CW'(1);
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: a clear always lands at zero
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R10: without a tick or clear the count holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/cdl_loss_flag.sv
module cdl_loss_flag #(
  parameter int MW = 8,
  parameter int CW = MW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ocd,
  input  logic          tick,
  input  logic [MW-1:0] m_limit,
  input  logic [CW-1:0] ocd_cnt,
  input  logic [CW-1:0] sync_cnt,
  output logic          lcd_q
);
  localparam int XW = CW + 1;

  logic [XW-1:0] lim_x, ocd_nx, sync_nx;
  logic          set_c, clr_c, lcd_en;

  assign lim_x   = XW'(m_limit);
  assign ocd_nx  = XW'(ocd_cnt) + XW'(1);
  assign sync_nx = XW'(sync_cnt) + XW'(1);

  assign set_c  = tick && ocd && !lcd_q && (ocd_nx >= lim_x);
  assign clr_c  = tick && !ocd && lcd_q && (sync_nx > lim_x);
  assign lcd_en = set_c | clr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lcd_q <= 1'b0;
    else if (lcd_en) lcd_q <= set_c;
  end

  // R8: the alarm only rises on a tick while out of delineation
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_q) |-> $past(ocd && tick));
  // R9: the alarm only falls on a tick while locked
  a_r9_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_q) |-> $past(!ocd && tick));
  // R8: no change without a tick
  a_r8_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lcd_q));
endmodule

// File: rtl/cell_sync_tracker.sv
module cell_sync_tracker
  import cdl_pkg::*;
#(
  parameter int ALPHA = 7,
  parameter int DELTA = 6,
  parameter int MW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_found,
  input  logic          cell_vld,
  input  logic          hec_ok,
  input  logic          ms_tick,
  input  logic [MW-1:0] m_limit,
  input  logic          pass_presync,
  output logic [1:0]    state,
  output logic          ocd,
  output logic          lcd,
  output logic          accept
);
  localparam int CW = MW + 1;

  cdl_state_e    st_q;
  logic          in_sync;
  logic [CW-1:0] ocd_cnt, sync_cnt;

  cdl_state_fsm #(.ALPHA(ALPHA), .DELTA(DELTA)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_found (cand_found),
    .cell_vld   (cell_vld),
    .hec_ok     (hec_ok),
    .st_q       (st_q)
  );

  assign in_sync = (st_q == CDL_SYNC);

  cdl_ms_timer #(.CW(CW)) u_ocd_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (in_sync),
    .tick  (ms_tick),
    .cnt_q (ocd_cnt)
  );

  cdl_ms_timer #(.CW(CW)) u_sync_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_sync),
    .tick  (ms_tick),
    .cnt_q (sync_cnt)
  );

  cdl_loss_flag #(.MW(MW), .CW(CW)) u_loss (
    .clk      (clk),
    .rst_n    (rst_n),
    .ocd      (!in_sync),
    .tick     (ms_tick),
    .m_limit  (m_limit),
    .ocd_cnt  (ocd_cnt),
    .sync_cnt (sync_cnt),
    .lcd_q    (lcd)
  );

  assign state  = st_q;
  assign ocd    = !in_sync;
  assign accept = cell_vld && hec_ok && pass_presync && (st_q == CDL_PRESYNC);

  // R10: the out-of-delineation timer is idle at zero after a locked cycle
  a_r10_ocd_tmr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |=> ocd_cnt == '0);
  // R9: the lock timer is idle at zero after an unlocked cycle
  a_r9_sync_tmr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> sync_cnt == '0);
endmodule

// File: tb/sim_cell_sync_tracker.sv
module sim_cell_sync_tracker;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cand_found, cell_vld, hec_ok, ms_tick, pass_presync;
  logic [MW-1:0] m_limit;
  logic [1:0]    state;
  logic          ocd, lcd, accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int m_st, m_run, m_ocdc, m_syncc;
  bit m_lcd;

  always #10 clk = ~clk;

  cell_sync_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cand_found(cand_found), .cell_vld(cell_vld),
    .hec_ok(hec_ok), .ms_tick(ms_tick), .m_limit(m_limit),
    .pass_presync(pass_presync), .state(state), .ocd(ocd), .lcd(lcd),
    .accept(accept)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit exp_acc;
    exp_acc = cell_vld && hec_ok && pass_presync && (m_st == 1);
    chk("R2/R3/R4/R5 state", int'(state), m_st);
    chk("R6 ocd", int'(ocd), int'(m_st != 2));
    chk("R8/R9/R10 lcd", int'(lcd), int'(m_lcd));
    chk("R7 accept", int'(accept), int'(exp_acc));
  endtask

  // behavioural step using values present before the edge
  task automatic model_step();
    bit o;
    o = (m_st != 2);
    if (ms_tick) begin
      if (o && !m_lcd && (m_ocdc + 1 >= int'(m_limit))) m_lcd = 1;
      else if (!o && m_lcd && (m_syncc + 1 > int'(m_limit))) m_lcd = 0;
    end
    if (o) begin
      m_syncc = 0;
      if (ms_tick) m_ocdc++;
    end else begin
      m_ocdc = 0;
      if (ms_tick) m_syncc++;
    end
    case (m_st)
      0: if (cand_found) begin m_st = 1; m_run = 0; end
      1: if (cell_vld) begin
           if (!hec_ok) begin m_st = 0; m_run = 0; end
           else if (m_run == 5) begin m_st = 2; m_run = 0; end
           else m_run++;
         end
      default: if (cell_vld) begin
           if (hec_ok) m_run = 0;
           else if (m_run == 6) begin m_st = 0; m_run = 0; end
           else m_run++;
         end
    endcase
  endtask

  task automatic do_reset(input int m, input bit pass);
    @(negedge clk);
    rst_n = 1'b0; cand_found = 0; cell_vld = 0; hec_ok = 0; ms_tick = 0;
    m_limit = MW'(m); pass_presync = pass;
    m_st = 0; m_run = 0; m_ocdc = 0; m_syncc = 0; m_lcd = 0;
    @(negedge clk);
    #2;
    // R1: reset values
    chk("R1 state", int'(state), 0);
    chk("R1 ocd", int'(ocd), 1);
    chk("R1 lcd", int'(lcd), 0);
    chk("R1 accept", int'(accept), 0);
    rst_n = 1'b1;
  endtask

  // mode 0 good-heavy, 1 bad-heavy, 2 mixed
  task automatic run_phase(input int cycles, input int mode);
    for (int i = 0; i < cycles; i++) begin
      int bad_pct;
      @(negedge clk);
      bad_pct = (mode == 0) ? 3 : (mode == 1) ? 60 : 25;
      cell_vld   = ($urandom % 4) != 0;
      hec_ok     = ($urandom % 100) >= bad_pct;
      cand_found = ($urandom % 6) == 0;
      ms_tick    = ($urandom % 5) == 0;
      #2;
      compare_all();
      @(posedge clk);
      model_step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int m = 1; m <= 5; m += 2) begin
      for (int p = 0; p < 2; p++) begin
        do_reset(m, p[0]);
        run_phase(1500, 0);
        run_phase(600, 1);
        run_phase(1500, 2);
        run_phase(1200, 0);
      end
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule